// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory whose reads and writes both complete in a data phase two rising edges after the command. Address, control and the per-lane write selects are registered on one edge. Write data is sampled two edges later. Read data is registered onto the output bus on that same later edge. Because both kinds of operation share the same delayed data slot, a host can issue any mix of reads and writes on consecutive cycles and never has to insert an idle cycle when the bus changes direction.

The word is split into byte lanes of nine bits each, four lanes by default. Each lane has its own active-low write select. Three chip enables qualify a newly loaded command. An advance input reuses the last loaded command instead of taking a new one: the burst sequencer steps through four consecutive words, and a parameter selects linear or interleaved order. An active-high hold input freezes the whole block. An asynchronous output-enable gates the output-valid flag. The block schedules its own output drive, so the host only needs the output-enable input to force the bus off.

Depth is a parameter; the default is 256 words, and the depth must be at least 8. A write followed within one or two cycles by a read of the same word returns the new bytes through a bypass path.

Top module: `zt_sram`

## Requirements
- R1: A command sampled on edge n has its data phase on edge n+2. For a write, `wdata` is sampled on edge n+2. For a read, `rdata` carries the word and `rdata_vld` is high from just after edge n+2 until edge n+3.
- R2: Reads and writes in any order can be issued on every cycle. Each one completes with the latency of R1, and no idle cycle is needed between them.
- R3: While `hold` is high, a rising edge changes no state. All other synchronous inputs, including `wdata`, are ignored, and `rdata`, `rdata_vld` and the memory contents keep their values.
- R4: A load (`burst_adv` low) while `en_a_n` is high, `en_b` is low or `en_c_n` is high starts no operation. Commands already in the pipeline still complete.
- R5: `rdata_vld` is low after edge n+2 when the command on edge n was a write or a deselect.
- R6: `out_en_n` high forces `rdata_vld` low at once, without waiting for a clock edge. It does not affect the pipeline or any stored data.
- R7: On a write, lane l (bits 9l+8 down to 9l) is stored only if `lane_we_n[l]` was low on the command edge. The other lanes keep their stored contents.
- R8: A read issued one or two cycles after a write to the same address returns the newly written lanes, combined with the unchanged lanes.
- R9: With `burst_adv` high, the block repeats the last loaded command type on the next address of a four-word burst. Address bits above bit 1 stay fixed. The low two bits are (base+k) mod 4 for linear order (`LINEAR_BURST`=1) or base XOR k for interleaved order, where k is 1, 2, 3, 0, 1, ... counting advances since the load.
- R10: An advance after reset, or after a load that was deselected, starts no operation.
- R11: While `rst` is high at an edge, the pipeline is emptied and `rdata_vld` goes low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: freeze every register, ignore inputs |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write, used on a load |
| burst_adv | input | 1 | 1 = advance burst, 0 = load new command |
| lane_we_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address for a load |
| wdata | input | LANES*LANE_W | Write data, sampled in the data phase |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
If a stage register held a wrong command type or address, the error would show at the ports on the data-phase edge of that command, two edges after issue. It would appear as a wrong `rdata_vld` level, or as a wrong word read back later from the address that was touched. A broken bypass or lane mask is caught by the next read of that word, because the bench compares every read against an arithmetic model of the memory. A burst counter or order fault shows as the wrong word within one to four cycles after the advance.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Number of words in one burst and width of its step counter.
  localparam int BURST_LEN = 4;
  localparam int BURST_CW  = $clog2(BURST_LEN);

  // Command kind travelling through the pipeline.
  typedef struct packed {
    logic vld;
    logic wr;
  } zt_kind_t;

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
  import zt_pkg::*;
#(
  parameter int AW           = 8,
  parameter bit LINEAR_BURST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          load,
  input  logic          sel_ok,
  input  logic          is_rd,
  input  logic [AW-1:0] ext_addr,
  output zt_kind_t      op_kind,
  output logic [AW-1:0] op_addr
);

  logic [AW-1:0]       base_q;
  logic [BURST_CW-1:0] cnt_q;
  logic [BURST_CW-1:0] nxt_cnt;
  logic [BURST_CW-1:0] lo_bits;
  logic                act_q;
  logic                wr_q;

  assign nxt_cnt = cnt_q + 1'b1;

  generate
    if (LINEAR_BURST) begin : g_linear
      assign lo_bits = base_q[BURST_CW-1:0] + nxt_cnt;
    end else begin : g_interleave
      assign lo_bits = base_q[BURST_CW-1:0] ^ nxt_cnt;
    end
  endgenerate

  always_comb begin
    if (load) begin
      op_kind.vld = sel_ok;
      op_kind.wr  = ~is_rd;
      op_addr     = ext_addr;
    end else begin
      op_kind.vld = act_q;
      op_kind.wr  = wr_q;
      op_addr     = {base_q[AW-1:BURST_CW], lo_bits};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (ce) begin
      if (load) begin
        base_q <= ext_addr;
        cnt_q  <= '0;
        act_q  <= sel_ok;
        wr_q   <= ~is_rd;
      end else begin
        cnt_q <= nxt_cnt;
      end
    end
  end

  // R4: a deselected load leaves no active burst behind.
  a_r4_desel_idle: assert property (@(posedge clk) disable iff (rst)
    (ce && load && !sel_ok) |=> !act_q);

  // R9: advancing never alters the burst base.
  a_r9_base_kept: assert property (@(posedge clk) disable iff (rst)
    (ce && !load) |=> $stable(base_q));

  // R3: no burst state moves while frozen.
  a_r3_seq_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> ($stable(cnt_q) && $stable(act_q) && $stable(base_q)));

endmodule

// File: rtl/zt_ctl_pipe.sv
module zt_ctl_pipe
  import zt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  zt_kind_t         op_kind,
  input  logic [AW-1:0]    op_addr,
  input  logic [LANES-1:0] op_be,
  output logic [AW-1:0]    rd_addr,
  output zt_kind_t         wb_kind,
  output logic [AW-1:0]    wb_addr,
  output logic [LANES-1:0] wb_be
);

  zt_kind_t         k1_q;
  logic [AW-1:0]    a1_q;
  logic [LANES-1:0] be1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      k1_q    <= '0;
      wb_kind <= '0;
    end else if (ce) begin
      k1_q    <= op_kind;
      wb_kind <= k1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (ce) begin
      a1_q    <= op_addr;
      be1_q   <= op_be;
      wb_addr <= a1_q;
      wb_be   <= be1_q;
    end
  end

  assign rd_addr = a1_q;

  // R2: each enabled edge moves the first stage into the data stage.
  a_r2_stage_flow: assert property (@(posedge clk) disable iff (rst)
    ce |=> (wb_kind == $past(k1_q)));

  // R4: an invalid command never becomes a valid stage.
  a_r4_no_phantom: assert property (@(posedge clk) disable iff (rst)
    (ce && !op_kind.vld) |=> !k1_q.vld);

endmodule

// File: rtl/zt_lane_ram.sv
module zt_lane_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int W     = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] mem_q;
  logic [W-1:0] byp_d_q;
  logic         byp_q;

  // Plain read-first RAM, suitable for block RAM inference.
  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[waddr] <= wdata;
      mem_q <= mem[raddr];
    end
  end

  // Same-edge write to the word being read: forward the new lane.
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (ce) begin
      byp_q <= we && (waddr == raddr);
    end
  end

  always_ff @(posedge clk) begin
    if (ce) byp_d_q <= wdata;
  end

  assign rdata = byp_q ? byp_d_q : mem_q;

  // R8: a collision returns the lane just written.
  a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
    (ce && we && (waddr == raddr)) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int LANES        = 4,
  parameter int LANE_W       = 9,
  parameter bit LINEAR_BURST = 1'b1,
  localparam int AW          = $clog2(DEPTH),
  localparam int DW          = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             en_a_n,
  input  logic             en_b,
  input  logic             en_c_n,
  input  logic             rd_nwr,
  input  logic             burst_adv,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             out_en_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_vld
);

  logic             ce;
  logic             sel_ok;
  zt_kind_t         op_kind;
  logic [AW-1:0]    op_addr;
  logic [AW-1:0]    rd_addr;
  zt_kind_t         wb_kind;
  logic [AW-1:0]    wb_addr;
  logic [LANES-1:0] wb_be;
  logic [DW-1:0]    ram_rd;
  logic [DW-1:0]    dout_q;
  logic             drive_q;
  logic             wb_write;
  logic             wb_read;

  assign ce       = ~hold;
  assign sel_ok   = ~en_a_n & en_b & ~en_c_n;
  assign wb_write = wb_kind.vld & wb_kind.wr;
  assign wb_read  = wb_kind.vld & ~wb_kind.wr;

  zt_burst_seq #(
    .AW          (AW),
    .LINEAR_BURST(LINEAR_BURST)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .load    (~burst_adv),
    .sel_ok  (sel_ok),
    .is_rd   (rd_nwr),
    .ext_addr(addr),
    .op_kind (op_kind),
    .op_addr (op_addr)
  );

  zt_ctl_pipe #(
    .AW   (AW),
    .LANES(LANES)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .op_kind(op_kind),
    .op_addr(op_addr),
    .op_be  (~lane_we_n),
    .rd_addr(rd_addr),
    .wb_kind(wb_kind),
    .wb_addr(wb_addr),
    .wb_be  (wb_be)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      zt_lane_ram #(
        .DEPTH(DEPTH),
        .AW   (AW),
        .W    (LANE_W)
      ) u_ram (
        .clk  (clk),
        .rst  (rst),
        .ce   (ce),
        .we   (wb_write & wb_be[l]),
        .waddr(wb_addr),
        .wdata(wdata[l*LANE_W +: LANE_W]),
        .raddr(rd_addr),
        .rdata(ram_rd[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  // Output stage: registered data and drive flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else if (ce) begin
      drive_q <= wb_read;
      if (wb_read) dout_q <= ram_rd;
    end
  end

  assign rdata     = dout_q;
  assign rdata_vld = drive_q & ~out_en_n;

  // R1: a read in its data phase drives the bus after that edge.
  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (ce && wb_kind.vld && !wb_kind.wr) |=> drive_q);

  // R5: a write or empty slot in its data phase releases the bus.
  a_r5_no_drive: assert property (@(posedge clk) disable iff (rst)
    (ce && !(wb_kind.vld && !wb_kind.wr)) |=> !drive_q);

  // R3: frozen edges leave the output stage untouched.
  a_r3_out_frozen: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> ($stable(drive_q) && $stable(dout_q)));

endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;

  localparam int AW = 8;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst;
  logic          hold;
  logic          en_a_n, en_b, en_c_n;
  logic          rd_nwr, burst_adv, out_en_n;
  logic [3:0]    lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata, rdata2;
  logic          rdata_vld, rdata_vld2;

  always #2.5 clk = ~clk;

  zt_sram dut (
    .clk(clk), .rst(rst), .hold(hold), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .rd_nwr(rd_nwr), .burst_adv(burst_adv), .lane_we_n(lane_we_n), .out_en_n(out_en_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  zt_sram #(.LINEAR_BURST(1'b0)) dut_il (
    .clk(clk), .rst(rst), .hold(hold), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .rd_nwr(rd_nwr), .burst_adv(burst_adv), .lane_we_n(lane_we_n), .out_en_n(out_en_n),
    .addr(addr), .wdata(wdata), .rdata(rdata2), .rdata_vld(rdata_vld2)
  );

  int checks = 0;
  int fails  = 0;
  int salt   = 1;
  bit done   = 0;
  bit il_mode = 0;

  // Reference model
  logic [DW-1:0] ref_mem [256];
  bit       p1_v, p1_w, p2_v, p2_w;
  int       p1_a, p2_a, p1_a2, p2_a2;
  logic [3:0] p1_be, p2_be;
  int       m_base;
  logic [1:0] m_cnt;
  bit       m_act, m_wr;
  bit       exp_en;
  logic [DW-1:0] exp_d, exp_d2;

  function automatic logic [DW-1:0] pat(int a, int s);
    return {4'(s), 32'(a * 32'h9E3779B1) ^ 32'(s * 40503)};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1; hold = 0; en_a_n = 1; en_b = 0; en_c_n = 1; rd_nwr = 1;
    burst_adv = 0; out_en_n = 0; lane_we_n = 4'hF; addr = '0; wdata = '0;
    p1_v = 0; p2_v = 0; p1_w = 0; p2_w = 0; m_act = 0; m_cnt = 0; m_base = 0;
    exp_en = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R11", {35'd0, rdata_vld}, 36'd0);
    rst = 0;
  endtask

  // One clock cycle: drive inputs, advance the model, check after the edge.
  // desel: 0 all enabled, 1 en_a_n high, 2 en_b low, 3 en_c_n high.
  task automatic cyc(input bit load, input int desel, input bit rd, input int a,
                     input logic [3:0] bn, input bit hld, input bit oen, input string tag);
    logic [DW-1:0] d;
    bit cv, cw;
    int ca, ca2;
    int k;
    d = (!hld && p2_v && p2_w) ? pat(p2_a, salt) : pat(4000 + a, salt);
    hold = hld; burst_adv = !load; en_a_n = (desel == 1); en_b = (desel != 2);
    en_c_n = (desel == 3); rd_nwr = rd; addr = AW'(a); lane_we_n = bn;
    wdata = d; out_en_n = oen;
    if (!hld) begin
      if (p2_v && p2_w)
        for (int l = 0; l < 4; l++)
          if (p2_be[l]) ref_mem[p2_a][l*9 +: 9] = d[l*9 +: 9];
      exp_en = p2_v && !p2_w;
      if (exp_en) begin
        exp_d  = ref_mem[p2_a];
        exp_d2 = ref_mem[p2_a2];
      end
      if (load) begin
        cv = (desel == 0); cw = !rd; ca = a; ca2 = a;
        m_base = a; m_cnt = 0; m_act = cv; m_wr = cw;
      end else begin
        m_cnt = m_cnt + 2'd1;
        k = int'(m_cnt);
        cv = m_act; cw = m_wr;
        ca  = (m_base & ~3) | ((m_base + k) & 3);
        ca2 = (m_base & ~3) | ((m_base ^ k) & 3);
      end
      p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_a2 = p1_a2; p2_be = p1_be;
      p1_v = cv; p1_w = cw; p1_a = ca; p1_a2 = ca2; p1_be = ~bn;
    end
    salt++;
    @(posedge clk);
    #1;
    chk(tag, {35'd0, rdata_vld}, {35'd0, exp_en && !oen});
    if (exp_en && !oen) chk(tag, rdata, exp_d);
    if (il_mode && exp_en && !oen) chk("R9", rdata2, exp_d2);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 2, 1, 0, 4'hF, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    do_reset();

    // R1: fill every word with back-to-back single writes.
    for (int a = 0; a < 256; a++) cyc(1, 0, 0, a, 4'h0, 0, 0, "R1");
    idle(2, "R5");

    // R9: bursts read in both orders from base 1.
    il_mode = 1;
    cyc(1, 0, 1, 1, 4'hF, 0, 0, "R9");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 4'hF, 0, 0, "R9");
    idle(2, "R9");
    il_mode = 0;

    // R1: single read, latency two edges.
    cyc(1, 0, 1, 17, 4'hF, 0, 0, "R1");
    idle(2, "R1");

    // R8: read one and two cycles after a write to the same word.
    cyc(1, 0, 0, 9, 4'h0, 0, 0, "R8");
    cyc(1, 0, 1, 9, 4'hF, 0, 0, "R8");
    cyc(1, 0, 1, 9, 4'hF, 0, 0, "R8");
    idle(2, "R8");

    // R7: partial lane writes, then immediate read.
    cyc(1, 0, 0, 12, 4'b1010, 0, 0, "R7");
    cyc(1, 0, 0, 13, 4'b0111, 0, 0, "R7");
    cyc(1, 0, 1, 12, 4'hF, 0, 0, "R7");
    cyc(1, 0, 1, 13, 4'hF, 0, 0, "R7");
    idle(2, "R7");

    // R4: each chip enable inactive alone; pending read still completes.
    cyc(1, 0, 1, 20, 4'hF, 0, 0, "R4");
    cyc(1, 1, 1, 21, 4'hF, 0, 0, "R4");
    cyc(1, 2, 0, 22, 4'h0, 0, 0, "R4");
    cyc(1, 3, 1, 23, 4'hF, 0, 0, "R4");
    idle(2, "R4");

    // R10: advances after a deselect start nothing.
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 4'hF, 0, 0, "R10");
    idle(1, "R10");

    // R5: write followed by read-after-write on the bus.
    cyc(1, 0, 1, 30, 4'hF, 0, 0, "R5");
    cyc(1, 0, 0, 31, 4'h0, 0, 0, "R5");
    cyc(1, 0, 1, 31, 4'hF, 0, 0, "R5");
    idle(2, "R5");

    // R6: asynchronous output enable.
    cyc(1, 0, 1, 40, 4'hF, 0, 0, "R6");
    idle(2, "R6");
    out_en_n = 1; #0.2;
    chk("R6", {35'd0, rdata_vld}, 36'd0);
    out_en_n = 0; #0.2;
    chk("R6", {35'd0, rdata_vld}, 36'd1);

    // R3: frozen cycles with junk inputs, in mid-pipeline.
    cyc(1, 0, 0, 50, 4'h0, 0, 0, "R3");
    cyc(1, 0, 1, 50, 4'hF, 0, 0, "R3");
    for (int i = 0; i < 5; i++) cyc(i[0], 0, i[1], 60 + i, 4'h0, 1, 0, "R3");
    idle(3, "R3");

    // R2: random mixes with bursts, holds and output-enable.
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 8) ? 0 : int'($urandom_range(1, 3)),
          $urandom_range(0, 1), ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 255)),
          4'($urandom_range(0, 15)), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), "R2");
    end
    idle(2, "R2");

    // R11: reset mid-traffic empties the pipeline.
    cyc(1, 0, 1, 3, 4'hF, 0, 0, "R11");
    do_reset();
    idle(2, "R11");

    summary();
  end

endmodule